// File: doc/BRIEF.md
# Translation Buffer Maintenance Registers

This block gives software indirect access to a small set-associative translation buffer. Three 32-bit registers sit on a simple read/write bus. The access register carries a frame number and permission flags. The control register carries a way selector, a process identifier and two command bits, one that arms entry writes and one that requests an entry read. The pointer register carries a page-table base and a virtual page number. Storing an entry and reading one back are side effects of ordinary register writes, and both complete at the clock edge that takes the write.

Entries are stored at index `way * SETS + (vpn mod SETS)`. The block keeps the page number from the last pointer write and the identifier from the last control write in private copies. These copies are separate from the values that software reads back, so an entry read can change what software sees without disturbing the operands of the next entry write. A combinational lookup port exposes any entry to a translation unit elsewhere in the chip. After each entry write the way selector steps forward, wrapping over the number of ways, so that a run of access writes fills consecutive ways.

Top module: `tlbm_maint`

## Requirements
- R1: After synchronous reset all three registers read 0 and every entry reports invalid, with every field zero, at the lookup port.
- R2: A write to the access register (address 0) while control bit 18 (write-arm) is set stores an entry at index way*SETS + (vpn mod SETS). The way comes from control bits [20 +: log2(NUM_WAYS)], the vpn from the last value written to pointer bits [21:2], and the identifier from the last value written to control bits [4 +: PID_BITS]. The global flag is taken from bit 24 of the written value.
- R3: The stored entry data keeps only the frame number (bits [19:0]) and the X (bit 20), W (bit 21), R (bit 22) and C (bit 23) flags of the written access value. Other bits are dropped. The lookup port shows the flags as lk_perm = {C,R,W,X}.
- R4: A newly stored entry is valid only when its vpn is below 0xC0000.
- R5: Each entry write advances the control register's way field by one, modulo NUM_WAYS.
- R6: Writing the access register never changes the value read back from it. Without write-arm, no entry changes.
- R7: A write to the control register (address 1) with bit 19 (read request) set loads the entry chosen by the written way field and the stored vpn. The access register then reads back entry data plus the global flag at bit 24, with bits [31:25] kept. The control register reads back the written value with its identifier field replaced by the entry's identifier. The pointer register's vpn field takes the entry's vpn.
- R8: A control write without the read request reads back exactly as written.
- R9: A write to the pointer register (address 2) updates bits [31:22] and [1:0] of its read-back value but not the vpn field [21:2]. The written vpn is still used by later entry writes and reads.
- R10: A bus read returns the read-back value of the addressed register one cycle later, with bus_rvalid high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 access, 1 control, 2 pointer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| lk_index | input | log2(NUM_WAYS*SETS) | Entry index for the lookup port |
| lk_valid | output | 1 | Entry valid flag |
| lk_global | output | 1 | Entry global flag |
| lk_vpn | output | 20 | Entry virtual page number |
| lk_pid | output | PID_BITS | Entry process identifier |
| lk_perm | output | 4 | Entry flags {C,R,W,X} |
| lk_pfn | output | 20 | Entry frame number |

## Verification
The bench builds the block with NUM_WAYS=2, SETS=4 and PID_BITS=8, so the array has eight entries. With two ways, the way field wraps after two entry writes. With four sets, page numbers that differ only above bit 1 share a set. The bench also writes page numbers 0xBFFFF and 0xC0000 to test both sides of the validity limit. It arms write and read in a single control write so that the identifier used for the next entry differs from the one read back.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int VPN_W = 20;
    localparam int PFN_W = 20;

    // access register layout
    localparam int ACC_X      = 20;
    localparam int ACC_W      = 21;
    localparam int ACC_R      = 22;
    localparam int ACC_C      = 23;
    localparam int ACC_G      = 24;
    localparam int ACC_IGN_LO = 25;

    // control register layout
    localparam int CTL_PID_LSB = 4;
    localparam int CTL_WE      = 18;
    localparam int CTL_RD      = 19;
    localparam int CTL_WAY_LSB = 20;

    // pointer register layout
    localparam int PTR_VPN_LSB = 2;
    localparam int PTR_VPN_MSB = PTR_VPN_LSB + VPN_W - 1;

    localparam logic [VPN_W-1:0] VPN_LIMIT = 20'hC0000;

    typedef enum logic [1:0] {
        REG_ACC = 2'd0,
        REG_CTL = 2'd1,
        REG_PTR = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             c;
        logic             r;
        logic             w;
        logic             x;
        logic [PFN_W-1:0] pfn;
    } entry_data_t;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [VPN_W-1:0] vpn;
    } entry_tag_t;

    function automatic entry_data_t acc_to_data(input logic [31:0] v);
        entry_data_t d;
        d.c   = v[ACC_C];
        d.r   = v[ACC_R];
        d.w   = v[ACC_W];
        d.x   = v[ACC_X];
        d.pfn = v[PFN_W-1:0];
        return d;
    endfunction

    function automatic logic [ACC_IGN_LO-1:0] data_to_acc(input entry_data_t d,
                                                          input logic g);
        logic [ACC_IGN_LO-1:0] v;
        v            = '0;
        v[PFN_W-1:0] = d.pfn;
        v[ACC_X]     = d.x;
        v[ACC_W]     = d.w;
        v[ACC_R]     = d.r;
        v[ACC_C]     = d.c;
        v[ACC_G]     = g;
        return v;
    endfunction

endpackage

// File: rtl/tlbm_array.sv
module tlbm_array
    import tlbm_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int PID_BITS = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  entry_tag_t          wtag,
    input  logic [PID_BITS-1:0] wpid,
    input  entry_data_t         wdata,
    input  logic [IDX_W-1:0]    ra_idx,
    output logic                ra_glob,
    output logic [VPN_W-1:0]    ra_vpn,
    output logic [PID_BITS-1:0] ra_pid,
    output entry_data_t         ra_data,
    input  logic [IDX_W-1:0]    rb_idx,
    output entry_tag_t          rb_tag,
    output logic [PID_BITS-1:0] rb_pid,
    output entry_data_t         rb_data
);

    entry_tag_t          tag_q  [ENTRIES];
    logic [PID_BITS-1:0] pid_q  [ENTRIES];
    entry_data_t         data_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                pid_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (we) begin
            tag_q[widx]  <= wtag;
            pid_q[widx]  <= wpid;
            data_q[widx] <= wdata;
        end
    end

    always_comb begin
        ra_glob = tag_q[ra_idx].glob;
        ra_vpn  = tag_q[ra_idx].vpn;
        ra_pid  = pid_q[ra_idx];
        ra_data = data_q[ra_idx];
        rb_tag  = tag_q[rb_idx];
        rb_pid  = pid_q[rb_idx];
        rb_data = data_q[rb_idx];
    end

    // R4: a stored entry is valid exactly when its page number is under the limit
    a_r4_valid_limit: assert property (@(posedge clk) disable iff (rst)
        we |=> (tag_q[$past(widx)].valid == ($past(wtag.vpn) < VPN_LIMIT)));

    // R2: the stored page number and identifier match the write port
    a_r2_store_fields: assert property (@(posedge clk) disable iff (rst)
        we |=> (tag_q[$past(widx)].vpn == $past(wtag.vpn))
            && (pid_q[$past(widx)] == $past(wpid)));

endmodule

// File: rtl/tlbm_regs.sv
module tlbm_regs
    import tlbm_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int SETS      = 16,
    parameter int PID_BITS  = 8,
    localparam int WAY_BITS = $clog2(NUM_WAYS),
    localparam int SET_BITS = $clog2(SETS),
    localparam int IDX_W    = WAY_BITS + SET_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    output logic                ent_we,
    output logic [IDX_W-1:0]    ent_widx,
    output entry_tag_t          ent_wtag,
    output logic [PID_BITS-1:0] ent_wpid,
    output entry_data_t         ent_wdata,
    output logic [IDX_W-1:0]    ent_ridx,
    input  logic                ent_rglob,
    input  logic [VPN_W-1:0]    ent_rvpn,
    input  logic [PID_BITS-1:0] ent_rpid,
    input  entry_data_t         ent_rdata
);

    logic [31:0]         acc_rb;
    logic [31:0]         ctl_rb;
    logic [31:0]         ptr_rb;
    logic [PID_BITS-1:0] pid_sh;
    logic [VPN_W-1:0]    vpn_sh;

    logic                acc_wr;
    logic                ctl_wr;
    logic                ptr_wr;
    logic [WAY_BITS-1:0] way_q;
    logic [31:0]         ctl_loaded;

    always_comb begin
        acc_wr = bus_wr && (bus_addr == REG_ACC);
        ctl_wr = bus_wr && (bus_addr == REG_CTL);
        ptr_wr = bus_wr && (bus_addr == REG_PTR);
        way_q  = ctl_rb[CTL_WAY_LSB +: WAY_BITS];

        ent_we         = acc_wr && ctl_rb[CTL_WE];
        ent_widx       = {way_q, vpn_sh[SET_BITS-1:0]};
        ent_wtag.valid = (vpn_sh < VPN_LIMIT);
        ent_wtag.glob  = bus_wdata[ACC_G];
        ent_wtag.vpn   = vpn_sh;
        ent_wpid       = pid_sh;
        ent_wdata      = acc_to_data(bus_wdata);

        ent_ridx = {bus_wdata[CTL_WAY_LSB +: WAY_BITS], vpn_sh[SET_BITS-1:0]};

        ctl_loaded = bus_wdata;
        ctl_loaded[CTL_PID_LSB +: PID_BITS] = ent_rpid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_rb     <= '0;
            ctl_rb     <= '0;
            ptr_rb     <= '0;
            pid_sh     <= '0;
            vpn_sh     <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                case (bus_addr)
                    REG_ACC: bus_rdata <= acc_rb;
                    REG_CTL: bus_rdata <= ctl_rb;
                    REG_PTR: bus_rdata <= ptr_rb;
                    default: bus_rdata <= '0;
                endcase
            end

            if (ent_we) begin
                ctl_rb[CTL_WAY_LSB +: WAY_BITS] <= way_q + 1'b1;
            end

            if (ctl_wr) begin
                pid_sh <= bus_wdata[CTL_PID_LSB +: PID_BITS];
                if (bus_wdata[CTL_RD]) begin
                    ctl_rb <= ctl_loaded;
                    acc_rb <= {acc_rb[31:ACC_IGN_LO], data_to_acc(ent_rdata, ent_rglob)};
                    ptr_rb[PTR_VPN_MSB:PTR_VPN_LSB] <= ent_rvpn;
                end else begin
                    ctl_rb <= bus_wdata;
                end
            end

            if (ptr_wr) begin
                vpn_sh <= bus_wdata[PTR_VPN_MSB:PTR_VPN_LSB];
                ptr_rb <= {bus_wdata[31:PTR_VPN_MSB+1],
                           ptr_rb[PTR_VPN_MSB:PTR_VPN_LSB],
                           bus_wdata[PTR_VPN_LSB-1:0]};
            end
        end
    end

    // R5: way field steps by one, wrapping, after every entry write
    a_r5_way_step: assert property (@(posedge clk) disable iff (rst)
        ent_we |=> ctl_rb[CTL_WAY_LSB +: WAY_BITS] == WAY_BITS'($past(way_q) + 1'b1));

    // R6: access writes leave the access read-back untouched
    a_r6_acc_hold: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> $stable(acc_rb));

    // R9: pointer writes leave the read-back page number untouched
    a_r9_ptr_vpn_hold: assert property (@(posedge clk) disable iff (rst)
        ptr_wr |=> $stable(ptr_rb[PTR_VPN_MSB:PTR_VPN_LSB]));

    // R8: a plain control write reads back as written
    a_r8_ctl_plain: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !bus_wdata[CTL_RD]) |=> ctl_rb == $past(bus_wdata));

    // R10: read data valid follows the read strobe by one cycle
    a_r10_rvalid: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

endmodule

// File: rtl/tlbm_maint.sv
module tlbm_maint
    import tlbm_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int SETS     = 16,
    parameter int PID_BITS = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic [1:0]                          bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    output logic                                bus_rvalid,
    input  logic [$clog2(NUM_WAYS*SETS)-1:0]    lk_index,
    output logic                                lk_valid,
    output logic                                lk_global,
    output logic [19:0]                         lk_vpn,
    output logic [PID_BITS-1:0]                 lk_pid,
    output logic [3:0]                          lk_perm,
    output logic [19:0]                         lk_pfn
);

    localparam int ENTRIES = NUM_WAYS * SETS;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic                ent_we;
    logic [IDX_W-1:0]    ent_widx;
    entry_tag_t          ent_wtag;
    logic [PID_BITS-1:0] ent_wpid;
    entry_data_t         ent_wdata;
    logic [IDX_W-1:0]    ent_ridx;
    logic                ent_rglob;
    logic [VPN_W-1:0]    ent_rvpn;
    logic [PID_BITS-1:0] ent_rpid;
    entry_data_t         ent_rdata;
    entry_tag_t          lk_tag;
    entry_data_t         lk_data;

    tlbm_regs #(
        .NUM_WAYS (NUM_WAYS),
        .SETS     (SETS),
        .PID_BITS (PID_BITS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .ent_we     (ent_we),
        .ent_widx   (ent_widx),
        .ent_wtag   (ent_wtag),
        .ent_wpid   (ent_wpid),
        .ent_wdata  (ent_wdata),
        .ent_ridx   (ent_ridx),
        .ent_rglob  (ent_rglob),
        .ent_rvpn   (ent_rvpn),
        .ent_rpid   (ent_rpid),
        .ent_rdata  (ent_rdata)
    );

    tlbm_array #(
        .ENTRIES  (ENTRIES),
        .PID_BITS (PID_BITS)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (ent_we),
        .widx    (ent_widx),
        .wtag    (ent_wtag),
        .wpid    (ent_wpid),
        .wdata   (ent_wdata),
        .ra_idx  (ent_ridx),
        .ra_glob (ent_rglob),
        .ra_vpn  (ent_rvpn),
        .ra_pid  (ent_rpid),
        .ra_data (ent_rdata),
        .rb_idx  (lk_index),
        .rb_tag  (lk_tag),
        .rb_pid  (lk_pid),
        .rb_data (lk_data)
    );

    always_comb begin
        lk_valid  = lk_tag.valid;
        lk_global = lk_tag.glob;
        lk_vpn    = lk_tag.vpn;
        lk_perm   = {lk_data.c, lk_data.r, lk_data.w, lk_data.x};
        lk_pfn    = lk_data.pfn;
    end

endmodule

// File: tb/tlbm_maint_bench.sv
module tlbm_maint_bench;

    localparam int NW    = 2;
    localparam int NS    = 4;
    localparam int PB    = 8;
    localparam int IDX_W = $clog2(NW*NS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             bus_rvalid;
    logic [IDX_W-1:0] lk_index = '0;
    logic             lk_valid;
    logic             lk_global;
    logic [19:0]      lk_vpn;
    logic [PB-1:0]    lk_pid;
    logic [3:0]       lk_perm;
    logic [19:0]      lk_pfn;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [31:0] q_exp [$];
    string       q_req [$];

    always #4 clk = ~clk;

    tlbm_maint #(.NUM_WAYS(NW), .SETS(NS), .PID_BITS(PB)) u_tlbm_maint (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .lk_index(lk_index), .lk_valid(lk_valid),
        .lk_global(lk_global), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
        .lk_perm(lk_perm), .lk_pfn(lk_pfn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue a read and queue the expected value
    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(exp);
        q_req.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compare each returned read against the queue
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (q_exp.size() == 0) begin
                chk("R10 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                chk(q_req.pop_front(), bus_rdata, q_exp.pop_front());
            end
        end
    end

    task automatic lk(input int idx, input logic v, input logic g, input logic [19:0] vpn,
                      input logic [7:0] pid, input logic [3:0] perm, input logic [19:0] pfn,
                      input string req);
        @(negedge clk);
        lk_index = IDX_W'(idx);
        #1;
        chk({req, " valid"},  {31'd0, lk_valid},  {31'd0, v});
        chk({req, " global"}, {31'd0, lk_global}, {31'd0, g});
        chk({req, " vpn"},    {12'd0, lk_vpn},    {12'd0, vpn});
        chk({req, " pid"},    {24'd0, lk_pid},    {24'd0, pid});
        chk({req, " perm"},   {28'd0, lk_perm},   {28'd0, perm});
        chk({req, " pfn"},    {12'd0, lk_pfn},    {12'd0, pfn});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 32'h0, "R1 acc reset");
        rd(2'd1, 32'h0, "R1 ctl reset");
        rd(2'd2, 32'h0, "R1 ptr reset");
        for (int i = 0; i < NW*NS; i++) lk(i, 0, 0, 0, 0, 0, 0, "R1 entry reset");

        // R9 pointer write keeps read-back vpn
        wr(2'd2, 32'h55448D14);
        rd(2'd2, 32'h55400000, "R9 ptr base only");
        // R8 plain control write
        wr(2'd1, 32'h00040A50);
        rd(2'd1, 32'h00040A50, "R8 ctl plain");

        // R2 R3 entry write with extra bits dropped
        wr(2'd0, 32'hFFDABCDE);
        rd(2'd0, 32'h0, "R6 acc readback held");
        rd(2'd1, 32'h00140A50, "R5 way step");
        lk(1, 1, 1, 20'h12345, 8'hA5, 4'b1101, 20'hABCDE, "R2 R3 entry way0");

        // second way, then wrap
        wr(2'd0, 32'h00200042);
        lk(5, 1, 0, 20'h12345, 8'hA5, 4'b0010, 20'h00042, "R2 entry way1");
        rd(2'd1, 32'h00040A50, "R5 way wrap");

        // R4 limit boundary
        wr(2'd2, 32'h00300000);
        rd(2'd2, 32'h0, "R9 ptr vpn held");
        wr(2'd0, 32'h00400007);
        lk(0, 0, 0, 20'hC0000, 8'hA5, 4'b0100, 20'h00007, "R4 vpn at limit");
        wr(2'd2, 32'h002FFFFC);
        wr(2'd0, 32'h01000001);
        lk(7, 1, 1, 20'hBFFFF, 8'hA5, 4'b0000, 20'h00001, "R4 vpn below limit");

        // R6 no write-arm: nothing stored
        wr(2'd1, 32'h00000330);
        wr(2'd0, 32'h00FFFFFF);
        lk(3, 0, 0, 0, 0, 0, 0, "R6 unarmed no store");
        rd(2'd1, 32'h00000330, "R6 way unchanged");
        rd(2'd2, 32'h0, "R9 ptr after writes");

        // R7 entry read
        wr(2'd2, 32'h00000004);
        wr(2'd1, 32'h00080770);
        rd(2'd0, 32'h01DABCDE, "R7 acc loaded");
        rd(2'd1, 32'h00080A50, "R7 ctl pid loaded");
        rd(2'd2, 32'h00048D14, "R7 ptr vpn loaded");

        // R2 identifier comes from written control value, not read-back
        wr(2'd1, 32'h000C0770);
        wr(2'd0, 32'h00000009);
        lk(1, 1, 0, 20'h00001, 8'h77, 4'b0000, 20'h00009, "R2 written pid used");
        rd(2'd1, 32'h001C0A50, "R5 way after armed read");
        rd(2'd0, 32'h01DABCDE, "R6 acc held after write");

        // R7 read from way 1
        wr(2'd1, 32'h00180000);
        rd(2'd0, 32'h00200042, "R7 acc way1");
        rd(2'd1, 32'h00180A50, "R7 ctl way1");
        rd(2'd2, 32'h00048D14, "R7 ptr way1");

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", q_exp.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule